// File: doc/BRIEF.md
# Three-Wire Mode Control Port

This block sets the operating flags of an audio converter: attenuation by 12 dB, double speed, mute and de-emphasis. A mode-select pin chooses how. When it is low, the four application pins are static controls and each one drives one flag. When it is high and application pin 3 is low, pins 0, 1 and 2 act as a serial port with data, clock and latch lines. A controller shifts in an 8-bit command most significant bit first and then moves it into the command register with a latch edge.

Each latched command is either a flag write or a step command, such as one step of a volume fade. A step command gives a one-cycle strobe together with its direction. The same command can be run again by pulsing the latch line while the clock line stays high. Two step commands that are accepted must be at least `GAP_CYCLES` clock cycles apart. A step command that comes too early is rejected and flagged, and it is not applied. All pins pass through a two-flop synchronizer before any edge is detected. This adds a fixed latency of a few cycles.

Top module: `mode_ctl_port`

## Requirements
- R1: When mode_sel_i is low, the flag outputs follow the synchronized pins: app_i[0] drives atten_o, app_i[1] drives dbl_speed_o, app_i[2] drives mute_o and app_i[3] drives deemph_o.
- R2: Shifting and latching happen only when mode_sel_i is high and app_i[3] is low. Pin activity at any other time leaves cmd_word_o unchanged. While mode_sel_i is high, the flag outputs come from the last flag-write command.
- R3: In serial mode, app_i[0] is the data line and app_i[1] is the clock line. One bit shifts in on each rising edge of app_i[1] while the latch line app_i[2] is low. The first bit shifted becomes bit 7. cmd_word_o changes only when a latch is accepted.
- R4: When more than 8 bits are shifted before a latch, only the last 8 bits are latched.
- R5: A rising edge on app_i[2] while app_i[1] is low is ignored.
- R6: A latched command with bit 7 = 0 is a flag write: bit 0 sets atten, bit 1 sets dbl_speed, bit 2 sets mute and bit 3 sets deemph. Bits 6..4 are ignored.
- R7: A latched command with bit 7 = 1 is a step command. It gives a one-cycle pulse on step_o with step_up_o equal to bit 6, and it leaves the flags unchanged.
- R8: A further latch rising edge while the clock line stays high runs the same command again.
- R9: A step command that arrives fewer than GAP_CYCLES cycles after the last accepted step gives a one-cycle step_rej_o pulse instead of step_o, and it does not restart the spacing timer.
- R10: Fewer than 8 bits shifted since the previous latch is not an error. The latch takes whatever the shift register holds at that moment.
- R11: After reset, cmd_word_o, all flags, step_o, step_up_o and step_rej_o are 0, and the shift register is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel_i | input | 1 | High selects serial control, low selects static pins |
| app_i | input | 4 | Application pins (asynchronous) |
| atten_o | output | 1 | 12 dB attenuation flag |
| dbl_speed_o | output | 1 | Double-speed flag |
| mute_o | output | 1 | Mute flag |
| deemph_o | output | 1 | De-emphasis flag |
| cmd_word_o | output | 8 | Last latched command |
| step_o | output | 1 | One-cycle strobe when a step command is applied |
| step_up_o | output | 1 | Direction of the last applied step (1 = up) |
| step_rej_o | output | 1 | One-cycle strobe when a step command is rejected for spacing |

## Verification
A corrupted shift register shows up on cmd_word_o only at the next accepted latch, which is three cycles after the latch pin rises. A wrong word is then seen on the flag outputs or as a step of the wrong direction. A spacing counter that is off by even one cycle turns a step into a rejection, or a rejection into a step, in the strobe stream. The scoreboard therefore compares every strobe against spacing computed from pin times. Faults in mode gating show up when cmd_word_o moves during static or held pin activity, which is checked a few cycles after each such burst.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    localparam int CMD_W = 8;

    typedef struct packed {
        logic deemph;
        logic mute;
        logic dbl;
        logic atten;
    } flags_t;

    typedef enum logic [1:0] {
        CK_FLAGS   = 2'd0,
        CK_STEP_DN = 2'd1,
        CK_STEP_UP = 2'd2
    } cmd_kind_e;

    function automatic cmd_kind_e classify(input logic [CMD_W-1:0] w);
        if (!w[CMD_W-1])
            return CK_FLAGS;
        return w[CMD_W-2] ? CK_STEP_UP : CK_STEP_DN;
    endfunction

    function automatic flags_t nibble_to_flags(input logic [3:0] n);
        return flags_t'(n);
    endfunction

endpackage

// File: rtl/mctl_sync.sv
module mctl_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    st[s] <= '0;
                else if (s == 0)
                    st[s] <= d_i;
                else
                    st[s] <= st[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = st[STAGES-1];
endmodule

// File: rtl/mctl_shifter.sv
module mctl_shifter #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             sdata_i,
    input  logic             sclk_i,
    input  logic             slat_i,
    output logic             accept_o,
    output logic             load_o,
    output logic [CMD_W-1:0] word_o
);
    logic             prev_clk, prev_lat;
    logic [CMD_W-1:0] shreg;
    logic             clk_rise, lat_rise;

    assign clk_rise = sclk_i & ~prev_clk;
    assign lat_rise = slat_i & ~prev_lat;
    assign accept_o = en_i & lat_rise & sclk_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            prev_lat <= 1'b0;
            shreg    <= '0;
            word_o   <= '0;
            load_o   <= 1'b0;
        end else begin
            prev_clk <= sclk_i;
            prev_lat <= slat_i;
            load_o   <= accept_o;
            if (en_i && clk_rise && !slat_i)
                shreg <= {shreg[CMD_W-2:0], sdata_i};
            if (accept_o)
                word_o <= shreg;
        end
    end
endmodule

// File: rtl/mctl_pacer.sv
module mctl_pacer #(
    parameter int GAP = 1_100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic up_i,
    output logic step_o,
    output logic step_up_o,
    output logic rej_o
);
    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] cnt;
    logic          ready;

    assign ready = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            step_o    <= 1'b0;
            step_up_o <= 1'b0;
            rej_o     <= 1'b0;
        end else begin
            step_o <= 1'b0;
            rej_o  <= 1'b0;
            if (!ready)
                cnt <= cnt - 1'b1;
            if (req_i) begin
                if (ready) begin
                    step_o    <= 1'b1;
                    step_up_o <= up_i;
                    cnt       <= CW'(GAP - 1);
                end else begin
                    rej_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mode_ctl_port.sv
module mode_ctl_port
    import mctl_pkg::*;
#(
    parameter int GAP_CYCLES  = 1_100_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel_i,
    input  logic [3:0]       app_i,
    output logic             atten_o,
    output logic             dbl_speed_o,
    output logic             mute_o,
    output logic             deemph_o,
    output logic [CMD_W-1:0] cmd_word_o,
    output logic             step_o,
    output logic             step_up_o,
    output logic             step_rej_o
);
    localparam int PIN_W = 5;

    logic [PIN_W-1:0] s_pins;
    logic             s_sel;
    logic [3:0]       s_app;
    logic             ser_en;
    logic             lat_accept;
    logic             load;
    cmd_kind_e        kind;
    flags_t           flag_reg;
    flags_t           flags;

    mctl_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({mode_sel_i, app_i}),
        .q_o (s_pins)
    );

    assign s_sel  = s_pins[4];
    assign s_app  = s_pins[3:0];
    assign ser_en = s_sel & ~s_app[3];

    mctl_shifter #(.CMD_W(CMD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .en_i     (ser_en),
        .sdata_i  (s_app[0]),
        .sclk_i   (s_app[1]),
        .slat_i   (s_app[2]),
        .accept_o (lat_accept),
        .load_o   (load),
        .word_o   (cmd_word_o)
    );

    assign kind = classify(cmd_word_o);

    always_ff @(posedge clk) begin
        if (rst)
            flag_reg <= '0;
        else if (load && kind == CK_FLAGS)
            flag_reg <= nibble_to_flags(cmd_word_o[3:0]);
    end

    mctl_pacer #(.GAP(GAP_CYCLES)) u_pace (
        .clk       (clk),
        .rst       (rst),
        .req_i     (load && kind != CK_FLAGS),
        .up_i      (kind == CK_STEP_UP),
        .step_o    (step_o),
        .step_up_o (step_up_o),
        .rej_o     (step_rej_o)
    );

    assign flags       = s_sel ? flag_reg : nibble_to_flags(s_app);
    assign atten_o     = flags.atten;
    assign dbl_speed_o = flags.dbl;
    assign mute_o      = flags.mute;
    assign deemph_o    = flags.deemph;
endmodule

// File: rtl/mode_ctl_port_chk.sv
module mode_ctl_port_chk #(
    parameter int GAP = 1_100_000
) (
    input logic       clk,
    input logic       rst,
    input logic       step_o,
    input logic       step_rej_o,
    input logic [7:0] cmd_word_o,
    input logic       accept,
    input logic       ser_en
);
    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst)
            since <= CW'(GAP);
        else if (step_o)
            since <= CW'(1);
        else if (since < CW'(GAP))
            since <= since + 1'b1;
    end

    a_r3_word_on_latch: assert property (@(posedge clk) disable iff (rst)
        (cmd_word_o != $past(cmd_word_o)) |-> $past(accept));

    a_r7_step_single: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);

    a_r9_step_xor_rej: assert property (@(posedge clk) disable iff (rst)
        !(step_o && step_rej_o));

    a_r9_gap_kept: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (since >= CW'(GAP)));

    a_r2_step_only_serial: assert property (@(posedge clk) disable iff (rst)
        step_o |-> $past(ser_en, 2));
endmodule

bind mode_ctl_port mode_ctl_port_chk #(.GAP(GAP_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_o     (step_o),
    .step_rej_o (step_rej_o),
    .cmd_word_o (cmd_word_o),
    .accept     (lat_accept),
    .ser_en     (ser_en)
);

// File: tb/mode_ctl_port_bench.sv
module mode_ctl_port_bench;
    localparam int GAP = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic [3:0] app = 4'b0000;
    logic       atten_o, dbl_speed_o, mute_o, deemph_o;
    logic [7:0] cmd_word_o;
    logic       step_o, step_up_o, step_rej_o;

    mode_ctl_port #(.GAP_CYCLES(GAP)) u_mode_ctl_port (
        .clk         (clk),
        .rst         (rst),
        .mode_sel_i  (mode_sel),
        .app_i       (app),
        .atten_o     (atten_o),
        .dbl_speed_o (dbl_speed_o),
        .mute_o      (mute_o),
        .deemph_o    (deemph_o),
        .cmd_word_o  (cmd_word_o),
        .step_o      (step_o),
        .step_up_o   (step_up_o),
        .step_rej_o  (step_rej_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct { bit rej; bit up; } ev_t;
    ev_t exp_q[$];

    logic [7:0] model_sh = 8'h00;
    bit         model_on = 0;
    int         last_ok  = -100000;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flags_is(input string req, input logic [3:0] exp);
        check(req, 32'({deemph_o, mute_o, dbl_speed_o, atten_o}), 32'(exp));
    endtask

    // clock line is left high after each bit
    task automatic send_bit(input bit b);
        app[1] = 1'b0;
        app[0] = b;
        wcyc(3);
        app[1] = 1'b1;
        if (model_on) model_sh = {model_sh[6:0], b};
        wcyc(3);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // latch pulse with clock line high; the driver pushes the expected strobe
    task automatic latch_hi();
        app[2] = 1'b1;
        if (model_on && model_sh[7]) begin
            ev_t e;
            e.up  = model_sh[6];
            e.rej = !((cyc - last_ok) >= GAP);
            if (!e.rej) last_ok = cyc;
            exp_q.push_back(e);
        end
        wcyc(4);
        app[2] = 1'b0;
        wcyc(4);
    endtask

    task automatic latch_lo();
        app[1] = 1'b0;
        wcyc(3);
        app[2] = 1'b1;
        wcyc(4);
        app[2] = 1'b0;
        wcyc(4);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && !done && (step_o || step_rej_o)) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected strobe", 32'({step_o, step_rej_o}), 32'h0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                check("R9 rejection", 32'(step_rej_o), 32'(e.rej));
                check("R7 step pulse", 32'(step_o), 32'(!e.rej));
                if (!e.rej) check("R7 direction", 32'(step_up_o), 32'(e.up));
            end
        end
    end

    initial begin
        wcyc(100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wcyc(4);
        rst = 1'b0;
        wcyc(2);
        // R11 reset state
        check("R11 word", 32'(cmd_word_o), 32'h0);
        flags_is("R11 flags", 4'h0);
        check("R11 strobes", 32'({step_o, step_up_o, step_rej_o}), 32'h0);

        // R1 static pins
        app = 4'b0101; wcyc(4);
        flags_is("R1 static 0101", 4'b0101);
        app = 4'b1010; wcyc(4);
        flags_is("R1 static 1010", 4'b1010);

        // R2 latch-like activity in static mode
        app = 4'b0010; wcyc(3);
        app = 4'b0110; wcyc(3);
        app = 4'b0010; wcyc(3);
        check("R2 static no latch", 32'(cmd_word_o), 32'h0);

        // R2 serial held off by app[3]
        mode_sel = 1'b1;
        app = 4'b1000; wcyc(4);
        model_on = 0;
        send_bit(1); send_bit(1); send_bit(1); send_bit(1);
        latch_hi();
        check("R2 held no latch", 32'(cmd_word_o), 32'h0);
        flags_is("R2 flags from register", 4'h0);

        app = 4'b0000; wcyc(4);
        model_on = 1;
        model_sh = 8'h00;

        // R3 / R6 flag write
        send_byte(8'h0B);
        check("R3 word before latch", 32'(cmd_word_o), 32'h0);
        latch_hi();
        check("R3 word latched", 32'(cmd_word_o), 32'(model_sh));
        flags_is("R6 flag write", 4'b1011);

        // R4 extra bits
        send_bit(1); send_bit(1); send_bit(1); send_bit(1);
        send_byte(8'h05);
        latch_hi();
        check("R4 last eight", 32'(cmd_word_o), 32'h05);
        flags_is("R6 flag write 2", 4'b0101);

        // R5 latch with clock low
        send_byte(8'h06);
        latch_lo();
        check("R5 ignored latch", 32'(cmd_word_o), 32'h05);

        // R10 short write
        send_bit(1); send_bit(0); send_bit(1);
        latch_hi();
        check("R10 short latch", 32'(cmd_word_o), 32'h35);
        flags_is("R10 flags", 4'b0101);

        // R7 step up, R9 too early, R8 repeat
        send_byte(8'hC0);
        latch_hi();
        check("R7 word", 32'(cmd_word_o), 32'hC0);
        flags_is("R7 flags kept", 4'b0101);
        latch_hi();
        wcyc(45);
        latch_hi();
        check("R8 word kept", 32'(cmd_word_o), 32'hC0);
        send_byte(8'h80);
        latch_hi();
        latch_hi();
        wcyc(10);
        check("R7 all strobes seen", 32'(exp_q.size()), 32'h0);

        // R1 back to static
        mode_sel = 1'b0;
        app = 4'b1100; wcyc(4);
        flags_is("R1 static again", 4'b1100);
        check("R2 word retained", 32'(cmd_word_o), 32'h80);

        done = 1;
        finish_run();
    end
endmodule